// File: doc/BRIEF.md
# Reset-Time Width and Channel-Mode Configuration Latch

This block decides, once per reset, how a two-channel memory-device model is wired into its system. While the active-low reset is held, every lane and termination control stays off. When reset is released, the release is brought into the command clock domain through a short synchronizer. Four strap lines are then sampled once: one data-side error-code line from each channel, and the CA6 command line of each channel. The result is frozen until the next reset.

The two error-code straps choose between full 16-bit width per channel and an 8-bit clamshell width. In the 8-bit width, the upper byte of channel A and the lower byte of channel B are switched off, so they are neither driven nor terminated. The CA6 straps choose between two independent channels and a pseudo-channel arrangement. In the pseudo-channel arrangement the upper command group is a shared bus, and only one channel terminates it. The per-channel low command group (CA[3:0]) stays terminated on both channels.

Top module: `strap_cfg_latch`

## Requirements
- R1: Straps are captured on the third rising clock edge after `rstN` goes high. `cfgLocked` is low after the first two of those edges and high from the third edge on.
- R2: If both width straps (`edcStrapA1`, `edcStrapB0`) read 0 at capture, `modeX8` is 1. If both read 1, `modeX8` is 0.
- R3: If the two width straps disagree at capture, `strapErr` is 1 and `modeX8` is 0. If they agree, `strapErr` is 0.
- R4: `modePseudo` is 1 only when both `ca6StrapA` and `ca6StrapB` read 0 at capture, and 0 for every other combination.
- R5: `laneEn` bit order is {B byte1, B byte0, A byte1, A byte0}, with bit 0 = A byte0. When locked, `laneEn` is 4'b1111 in 16-bit width and 4'b1001 in 8-bit width. A lane bit of 0 means that lane is neither driven nor terminated.
- R6: When locked, `termLowEn` (bit 0 = channel A, bit 1 = channel B) is 2'b11. `termSharedEn` is 2'b11 in two-channel mode and 2'b01 (channel A only) in pseudo-channel mode.
- R7: Strap changes after lock have no effect on any output.
- R8: A low `rstN` clears every output to 0 at once, without waiting for a clock edge, and the outputs stay 0 while reset is held.
- R9: A new reset followed by release recaptures the straps present at the new capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Asynchronous active-low reset |
| edcStrapA1 | input | 1 | Width strap, channel A upper-byte error-code line |
| edcStrapB0 | input | 1 | Width strap, channel B lower-byte error-code line |
| ca6StrapA | input | 1 | Channel-mode strap, CA6 of channel A |
| ca6StrapB | input | 1 | Channel-mode strap, CA6 of channel B |
| modeX8 | output | 1 | 8-bit clamshell width selected |
| modePseudo | output | 1 | Pseudo-channel mode selected |
| strapErr | output | 1 | Width straps disagreed at capture |
| cfgLocked | output | 1 | Configuration captured and frozen |
| laneEn | output | 4 | Per-byte lane drive and termination enable |
| termLowEn | output | 2 | Termination enable, CA[3:0] group per channel |
| termSharedEn | output | 2 | Termination enable, CA[9:4]/clock-enable/inversion group per channel |

## Verification
The assertions assume that the straps are steady across the capture edge. They also assume that `rstN` is released only while the clock is running, so the synchronizer output rises only after a clean release. The stimulus meets both conditions: it changes straps and reset only on falling clock edges, and it holds the straps for several cycles around each release. To show that the latch is frozen, it inverts every strap after lock. All sixteen strap combinations are swept, each with its own reset.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic locked;
  } cfgStrobe_t;

  // frozen mode word
  typedef struct packed {
    logic x8;
    logic pseudo;
    logic err;
  } cfgMode_t;

endpackage

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  output cfgStrobe_t strobe
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] syncQ;
  logic         lockedQ;
  logic         captureW;

  // release synchronizer: shifts ones in after reset deasserts
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[MSB-1:0], 1'b1};
      end
    end
  endgenerate

  assign captureW = syncQ[MSB] & ~lockedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lockedQ <= 1'b0;
    else if (captureW) lockedQ <= 1'b1;
  end

  assign strobe.capture = captureW;
  assign strobe.locked  = lockedQ;

  // R1
  capture_then_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> strobe.locked);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.locked |=> strobe.locked && !strobe.capture);

  // R1
  no_early_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncQ[MSB] |-> !strobe.locked);

endmodule

// File: rtl/strap_cfg_data.sv
module strap_cfg_data
  import strap_cfg_pkg::*;
#(
  parameter int                 NUM_CH      = 2,
  parameter int                 BYTES_PER_CH = 2,
  parameter logic [NUM_CH*BYTES_PER_CH-1:0] X8_OFF_MASK = 4'b0110
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cfgStrobe_t                        strobe,
  input  logic                              edcA1,
  input  logic                              edcB0,
  input  logic                              ca6A,
  input  logic                              ca6B,
  output cfgMode_t                          mode,
  output logic [NUM_CH*BYTES_PER_CH-1:0]    laneEn,
  output logic [NUM_CH-1:0]                 termLowEn,
  output logic [NUM_CH-1:0]                 termSharedEn
);

  localparam int NUM_LANES = NUM_CH * BYTES_PER_CH;

  cfgMode_t modeQ;
  cfgMode_t modeD;

  // decode: x8 only on unanimous low, mixed reading flags and falls back
  always_comb begin
    modeD.x8     = ~edcA1 & ~edcB0;
    modeD.err    = edcA1 ^ edcB0;
    modeD.pseudo = ~ca6A & ~ca6B;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               modeQ <= '0;
    else if (strobe.capture) modeQ <= modeD;
  end

  assign mode = modeQ;

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign laneEn[i] = strobe.locked & ~(modeQ.x8 & X8_OFF_MASK[i]);
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign termLowEn[c] = strobe.locked;
      if (c == 0) begin : g_owner
        assign termSharedEn[c] = strobe.locked;
      end else begin : g_follower
        assign termSharedEn[c] = strobe.locked & ~modeQ.pseudo;
      end
    end
  endgenerate

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.locked |=> $stable(modeQ.x8) && $stable(modeQ.pseudo) && $stable(modeQ.err));

  // R8
  idle_before_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.locked |-> (laneEn == '0) && (termSharedEn == '0) && (termLowEn == '0));

  // R3
  err_not_x8_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeQ.err |-> !modeQ.x8);

  // R5
  x8_lanes_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeQ.x8 |-> ((laneEn & X8_OFF_MASK) == '0));

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       edcStrapA1,
  input  logic       edcStrapB0,
  input  logic       ca6StrapA,
  input  logic       ca6StrapB,
  output logic       modeX8,
  output logic       modePseudo,
  output logic       strapErr,
  output logic       cfgLocked,
  output logic [3:0] laneEn,
  output logic [1:0] termLowEn,
  output logic [1:0] termSharedEn
);

  cfgStrobe_t strobe;
  cfgMode_t   mode;

  strap_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  strap_cfg_data #(
    .NUM_CH      (2),
    .BYTES_PER_CH(2),
    .X8_OFF_MASK (4'b0110)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .edcA1        (edcStrapA1),
    .edcB0        (edcStrapB0),
    .ca6A         (ca6StrapA),
    .ca6B         (ca6StrapB),
    .mode         (mode),
    .laneEn       (laneEn),
    .termLowEn    (termLowEn),
    .termSharedEn (termSharedEn)
  );

  assign modeX8     = mode.x8;
  assign modePseudo = mode.pseudo;
  assign strapErr   = mode.err;
  assign cfgLocked  = strobe.locked;

endmodule

// File: tb/strap_cfg_latch_tb.sv
module strap_cfg_latch_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       edcStrapA1 = 1'b1, edcStrapB0 = 1'b1, ca6StrapA = 1'b1, ca6StrapB = 1'b1;
  logic       modeX8, modePseudo, strapErr, cfgLocked;
  logic [3:0] laneEn;
  logic [1:0] termLowEn, termSharedEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg_latch u_dut (
    .clk(clk), .rstN(rstN),
    .edcStrapA1(edcStrapA1), .edcStrapB0(edcStrapB0),
    .ca6StrapA(ca6StrapA), .ca6StrapB(ca6StrapB),
    .modeX8(modeX8), .modePseudo(modePseudo), .strapErr(strapErr),
    .cfgLocked(cfgLocked), .laneEn(laneEn),
    .termLowEn(termLowEn), .termSharedEn(termSharedEn)
  );

  function automatic logic [11:0] outVec();
    return {strapErr, modeX8, modePseudo, cfgLocked, laneEn, termLowEn, termSharedEn};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] prevVec = '0;
    for (int v = 0; v < 16; v++) begin
      logic a1, b0, ca, cb, expX8, expErr, expPs;
      logic [3:0] expLane;
      logic [1:0] expShared;
      logic [11:0] expVec;
      {a1, b0, ca, cb} = v[3:0];
      expX8     = !a1 && !b0;
      expErr    = a1 ^ b0;
      expPs     = !ca && !cb;
      expLane   = expX8 ? 4'b1001 : 4'b1111;
      expShared = expPs ? 2'b01 : 2'b11;
      expVec    = {expErr, expX8, expPs, 1'b1, expLane, 2'b11, expShared};

      // R8: asynchronous clear, no clock edge in between
      @(negedge clk);
      rstN = 1'b0;
      #1;
      check("R8 async clear", outVec(), 12'h000);
      edcStrapA1 = a1; edcStrapB0 = b0; ca6StrapA = ca; ca6StrapB = cb;
      @(negedge clk);
      check("R8 held in reset", outVec(), 12'h000);

      rstN = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1 not locked after two edges", {11'd0, cfgLocked}, 12'd0);
      @(negedge clk);
      check("R1 locked on third edge", {11'd0, cfgLocked}, 12'd1);
      check("R2 width", {11'd0, modeX8}, {11'd0, expX8});
      check("R3 strap error", {11'd0, strapErr}, {11'd0, expErr});
      check("R4 pseudo", {11'd0, modePseudo}, {11'd0, expPs});
      check("R5 lanes", {8'd0, laneEn}, {8'd0, expLane});
      check("R6 termination", {8'd0, termLowEn, termSharedEn}, {8'd0, 2'b11, expShared});
      if (v > 0 && prevVec != expVec)
        check("R9 recapture", outVec(), expVec);
      prevVec = expVec;

      // R7: invert all straps after lock
      edcStrapA1 = ~a1; edcStrapB0 = ~b0; ca6StrapA = ~ca; ca6StrapB = ~cb;
      repeat (4) @(negedge clk);
      check("R7 frozen after strap change", outVec(), expVec);
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule